// File: doc/BRIEF.md
# Segmented Physical Address Generator

This unit turns a 16-bit effective offset and a 16-bit segment base into a 20-bit physical address, giving a 1 MB reach from 16-bit registers. It holds four segment bases: code, data, stack and extra. They are loaded through a single write port. The offset is built from the operand addressing mode in use, from one of these:

- a displacement alone
- a single register
- a register plus displacement
- a base plus an index, with or without a displacement

The unit picks a default segment from the registers involved. The caller may force any segment in its place. A second output gives the instruction-fetch address, formed from the code segment and the instruction pointer.

Register values, the displacement and the mode arrive as inputs from the decode stage. The effective offset and both physical addresses are combinational outputs. The only state is the four segment bases.

Top module: `seg_addr_gen`

## Requirements
- R1: The physical address equals (segment × 16 + offset) modulo 2^20. For example, segment F000h-style wrap: FFFFh with offset 0020h gives 00010h.
- R2: `fetch_addr` equals the code segment × 16 plus `ip`, modulo 2^20. For example, code segment 4000h with ip 9F20h gives 49F20h.
- R3: Mode 0 (direct) uses the displacement as the offset with the data segment. Mode codes 5, 6 and 7 behave exactly as mode 0.
- R4: When `disp_wide` is 0, only `disp[7:0]` is used, sign-extended to 16 bits. When it is 1, all 16 bits are used.
- R5: Mode 1 uses one register as the offset. Mode 2 uses one register plus the displacement. In both, `single_idx`=0 selects `base_val` and `single_idx`=1 selects `index_val`. The default segment is stack when the base is BP (`base_bp`=1), and data otherwise.
- R6: In modes 1 and 2 with `single_idx`=1, the default segment is extra when both `index_di`=1 and `str_dst`=1. Otherwise it is data.
- R7: Mode 3 uses base + index as the offset. Mode 4 uses base + index + displacement. The default segment is stack when `base_bp`=1, and data otherwise.
- R8: The offset sum wraps modulo 2^16 before it is added to the shifted segment.
- R9: When `ovr_en` is 1, the segment named by `ovr_sel` replaces the default segment for the data address. Segment codes are 0 code, 1 data, 2 stack and 3 extra.
- R10: Reset clears all four segment bases to zero. A write with `seg_we`=1 loads `seg_wdata` into the segment named by `seg_wsel`, and the new value is visible from the cycle after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seg_we | input | 1 | Segment write enable |
| seg_wsel | input | 2 | Segment to write (0 code, 1 data, 2 stack, 3 extra) |
| seg_wdata | input | 16 | Segment write value |
| ip | input | 16 | Instruction pointer |
| mode | input | 3 | Addressing mode |
| base_val | input | 16 | Base register value (BX or BP) |
| base_bp | input | 1 | Base register is BP |
| index_val | input | 16 | Index register value (SI or DI) |
| index_di | input | 1 | Index register is DI |
| single_idx | input | 1 | Single-register modes take the index register |
| str_dst | input | 1 | Access is a string destination |
| disp | input | 16 | Displacement |
| disp_wide | input | 1 | Displacement is 16-bit |
| ovr_en | input | 1 | Segment override enable |
| ovr_sel | input | 2 | Override segment code |
| eff_offset | output | 16 | Effective offset |
| phys_addr | output | 20 | Data physical address |
| fetch_addr | output | 20 | Instruction-fetch physical address |

## Verification
The assertions assume every input is a known value on each clock edge.

The write-visibility properties also assume that a segment named in an override, or the code segment, is not written again in the very cycle it is checked. The bench honours this by separating every segment write from the next read by at least one idle edge. It holds `seg_we` low during reset.

All stimulus changes at the falling edge. Results are sampled one time unit later, so the combinational outputs have settled.

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int OFS_W = 16,
  parameter int SHIFT = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   seg_we,
  input  logic [1:0]             seg_wsel,
  input  logic [OFS_W-1:0]       seg_wdata,
  input  logic [OFS_W-1:0]       ip,
  input  logic [2:0]             mode,
  input  logic [OFS_W-1:0]       base_val,
  input  logic                   base_bp,
  input  logic [OFS_W-1:0]       index_val,
  input  logic                   index_di,
  input  logic                   single_idx,
  input  logic                   str_dst,
  input  logic [OFS_W-1:0]       disp,
  input  logic                   disp_wide,
  input  logic                   ovr_en,
  input  logic [1:0]             ovr_sel,
  output logic [OFS_W-1:0]       eff_offset,
  output logic [OFS_W+SHIFT-1:0] phys_addr,
  output logic [OFS_W+SHIFT-1:0] fetch_addr
);
  localparam int PA_W = OFS_W + SHIFT;
  localparam logic [1:0] SEG_CODE  = 2'd0;
  localparam logic [1:0] SEG_DATA  = 2'd1;
  localparam logic [1:0] SEG_STACK = 2'd2;
  localparam logic [1:0] SEG_EXTRA = 2'd3;

  logic [OFS_W-1:0] seg_q [4];
  logic [OFS_W-1:0] disp_ext, single_val;
  logic [1:0]       single_seg, dflt_seg, use_seg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) seg_q[i] <= '0;
    end else if (seg_we) begin
      seg_q[seg_wsel] <= seg_wdata;
    end
  end

  assign disp_ext   = disp_wide ? disp : {{(OFS_W-8){disp[7]}}, disp[7:0]};
  assign single_val = single_idx ? index_val : base_val;
  assign single_seg = single_idx ? ((index_di && str_dst) ? SEG_EXTRA : SEG_DATA)
                                 : (base_bp ? SEG_STACK : SEG_DATA);

  always_comb begin
    case (mode)
      3'd1: begin eff_offset = single_val;                       dflt_seg = single_seg; end
      3'd2: begin eff_offset = single_val + disp_ext;            dflt_seg = single_seg; end
      3'd3: begin eff_offset = base_val + index_val;             dflt_seg = base_bp ? SEG_STACK : SEG_DATA; end
      3'd4: begin eff_offset = base_val + index_val + disp_ext;  dflt_seg = base_bp ? SEG_STACK : SEG_DATA; end
      default: begin eff_offset = disp_ext;                      dflt_seg = SEG_DATA; end
    endcase
  end

  assign use_seg    = ovr_en ? ovr_sel : dflt_seg;
  assign phys_addr  = {seg_q[use_seg], {SHIFT{1'b0}}} + PA_W'(eff_offset);
  assign fetch_addr = {seg_q[SEG_CODE], {SHIFT{1'b0}}} + PA_W'(ip);
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int OFS_W = 16,
  parameter int SHIFT = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   seg_we,
  input logic [1:0]             seg_wsel,
  input logic [OFS_W-1:0]       seg_wdata,
  input logic [OFS_W-1:0]       ip,
  input logic [2:0]             mode,
  input logic [OFS_W-1:0]       base_val,
  input logic [OFS_W-1:0]       index_val,
  input logic [OFS_W-1:0]       disp,
  input logic                   disp_wide,
  input logic                   ovr_en,
  input logic [1:0]             ovr_sel,
  input logic [OFS_W-1:0]       eff_offset,
  input logic [OFS_W+SHIFT-1:0] phys_addr,
  input logic [OFS_W+SHIFT-1:0] fetch_addr
);
  localparam int PA_W = OFS_W + SHIFT;

  assert_low_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[SHIFT-1:0] == eff_offset[SHIFT-1:0]);

  assert_direct_wide_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && disp_wide) |-> eff_offset == disp);

  assert_direct_sext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && !disp_wide) |-> eff_offset == {{(OFS_W-8){disp[7]}}, disp[7:0]});

  assert_based_sum_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3) |-> eff_offset == OFS_W'(base_val + index_val));

  assert_code_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_we && seg_wsel == 2'd0) |=>
      fetch_addr == PA_W'({$past(seg_wdata), {SHIFT{1'b0}}} + PA_W'(ip)));

  assert_ovr_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(seg_we) && ovr_en && ovr_sel == $past(seg_wsel)) |->
      phys_addr == PA_W'({$past(seg_wdata), {SHIFT{1'b0}}} + PA_W'(eff_offset)));
endmodule

bind seg_addr_gen seg_addr_gen_chk #(.OFS_W(OFS_W), .SHIFT(SHIFT)) u_chk (
  .clk(clk), .rst_n(rst_n), .seg_we(seg_we), .seg_wsel(seg_wsel),
  .seg_wdata(seg_wdata), .ip(ip), .mode(mode), .base_val(base_val),
  .index_val(index_val), .disp(disp), .disp_wide(disp_wide),
  .ovr_en(ovr_en), .ovr_sel(ovr_sel), .eff_offset(eff_offset),
  .phys_addr(phys_addr), .fetch_addr(fetch_addr)
);

// File: tb/sim_seg_addr_gen.sv
`timescale 1ns/1ps
module sim_seg_addr_gen;
  logic clk = 0, rst_n = 0;
  logic seg_we = 0;
  logic [1:0] seg_wsel = 0, ovr_sel = 0;
  logic [15:0] seg_wdata = 0, ip = 0, base_val = 0, index_val = 0, disp = 0;
  logic [2:0] mode = 0;
  logic base_bp = 0, index_di = 0, single_idx = 0, str_dst = 0, disp_wide = 0, ovr_en = 0;
  logic [15:0] eff_offset;
  logic [19:0] phys_addr, fetch_addr;
  int checks = 0, errors = 0;
  bit done = 0;

  seg_addr_gen u0 (.*);

  always #5 clk = ~clk;

  function automatic logic [19:0] pa(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o};
  endfunction

  task automatic chk(input string req, input logic [19:0] got, input logic [19:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %05h expected %05h", req, got, exp);
    end
  endtask

  task automatic wr_seg(input logic [1:0] s, input logic [15:0] v);
    @(negedge clk); seg_we = 1; seg_wsel = s; seg_wdata = v;
    @(negedge clk); seg_we = 0;
    @(negedge clk);
  endtask

  task automatic drive(input logic [2:0] m, input logic [15:0] b, input logic bp,
                       input logic [15:0] x, input logic di, input logic si,
                       input logic sd, input logic [15:0] d, input logic w);
    @(negedge clk);
    mode = m; base_val = b; base_bp = bp; index_val = x; index_di = di;
    single_idx = si; str_dst = sd; disp = d; disp_wide = w;
    #1;
  endtask

  task automatic t_reset;
    ip = 16'h1234;
    #1 chk("R10 reset fetch", fetch_addr, 20'h01234);
    chk("R10 reset phys", phys_addr, 20'h00000);
  endtask

  task automatic t_fetch;
    wr_seg(2'd0, 16'h4000); ip = 16'h9F20; #1;
    chk("R2 fetch 49F20", fetch_addr, 20'h49F20);
    wr_seg(2'd1, 16'h1000); wr_seg(2'd2, 16'h2000); wr_seg(2'd3, 16'h3000);
  endtask

  task automatic t_direct;
    drive(3'd0, 0, 0, 0, 0, 0, 0, 16'h5000, 1);
    chk("R3 direct eff", {4'h0, eff_offset}, 20'h05000);
    chk("R3 direct pa", phys_addr, 20'h15000);
    drive(3'd6, 0, 0, 0, 0, 0, 0, 16'h5000, 1);
    chk("R3 reserved mode", phys_addr, 20'h15000);
    drive(3'd0, 0, 0, 0, 0, 0, 0, 16'h1280, 0);
    chk("R4 sext neg", phys_addr, pa(16'h1000, 16'hFF80));
    drive(3'd0, 0, 0, 0, 0, 0, 0, 16'hAB7F, 0);
    chk("R4 sext pos", {4'h0, eff_offset}, 20'h0007F);
  endtask

  task automatic t_single;
    drive(3'd1, 16'h0100, 0, 16'h0300, 0, 0, 0, 0, 0);
    chk("R5 BX", phys_addr, 20'h10100);
    drive(3'd1, 16'h0200, 1, 16'h0300, 0, 0, 0, 0, 0);
    chk("R5 BP stack", phys_addr, 20'h20200);
    drive(3'd1, 16'h0100, 0, 16'h0300, 0, 1, 0, 0, 0);
    chk("R5 SI", phys_addr, 20'h10300);
    drive(3'd1, 16'h0100, 0, 16'h0400, 1, 1, 1, 0, 0);
    chk("R6 DI string", phys_addr, 20'h30400);
    drive(3'd1, 16'h0100, 0, 16'h0400, 1, 1, 0, 0, 0);
    chk("R6 DI plain", phys_addr, 20'h10400);
    drive(3'd2, 16'h0100, 0, 0, 0, 0, 0, 16'h0050, 0);
    chk("R5 relative", phys_addr, 20'h10150);
  endtask

  task automatic t_based;
    drive(3'd3, 16'h0100, 0, 16'h0300, 0, 0, 0, 16'h0777, 1);
    chk("R7 BX+SI", phys_addr, 20'h10400);
    drive(3'd4, 16'h0200, 1, 16'h0400, 1, 0, 0, 16'h1000, 1);
    chk("R7 BP+DI+disp", phys_addr, 20'h21600);
    drive(3'd3, 16'hFFFF, 0, 16'h0002, 0, 0, 0, 0, 0);
    chk("R8 offset wrap", phys_addr, 20'h10001);
    drive(3'd4, 16'h0010, 0, 16'h0000, 0, 0, 0, 16'h00F0, 0);
    chk("R8 neg disp wrap", {4'h0, eff_offset}, 20'h00000);
  endtask

  task automatic t_override;
    wr_seg(2'd3, 16'hFFFF);
    @(negedge clk); ovr_en = 1; ovr_sel = 2'd3;
    drive(3'd0, 0, 0, 0, 0, 0, 0, 16'h0020, 1);
    chk("R1 R9 20-bit wrap", phys_addr, 20'h00010);
    ovr_sel = 2'd1;
    drive(3'd1, 16'h0200, 1, 0, 0, 0, 0, 0, 0);
    chk("R9 BP to data", phys_addr, 20'h10200);
    ovr_en = 0; #1;
    chk("R9 no override", phys_addr, 20'h20200);
  endtask

  task automatic t_write_timing;
    @(negedge clk); mode = 3'd0; disp = 16'h0000; disp_wide = 1;
    seg_we = 1; seg_wsel = 2'd1; seg_wdata = 16'hABCD; #1;
    chk("R10 before edge", phys_addr, 20'h10000);
    @(negedge clk); seg_we = 0; #1;
    chk("R10 after edge", phys_addr, 20'hABCD0);
  endtask

  initial begin
    #17 rst_n = 1;
    t_reset; t_fetch; t_direct; t_single; t_based; t_override; t_write_timing;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule